// File: doc/BRIEF.md
# Windowed Multi-Channel Result Watchdog

This block watches a stream of conversion results and reports when a result leaves a programmable value window. Each result arrives as a one-cycle valid strobe together with its channel number, its value and a tag that marks it as a regular or an injected conversion. Three independent guards each compare the result against their own lower and upper limit. A guard raises a sticky flag when a result on a channel it watches falls outside its window.

Guard one watches either one chosen channel or every channel. It has separate enables for regular and injected results. It can also require a run of consecutive out-of-window results before it raises its flag. Guards two and three choose their channels through a per-channel bit mask and react to results of either tag. Software clears each flag by writing a one to it. A single interrupt line is the OR of the flags whose enable bits are set.

The configuration inputs are meant to be static while results flow. Converter control and result post-processing sit outside this block.

Top module: `result_window_guard`

## Requirements
- R1: A result counts as outside a guard's window only when its value is strictly greater than the upper limit or strictly less than the lower limit. A value equal to either limit is inside.
- R2: With `g1_all` = 0, guard one reacts only to results whose channel number equals `g1_chan`.
- R3: With `g1_all` = 1, guard one reacts to results on every channel.
- R4: Guard one reacts to regular results (`res_injected` = 0) only when `g1_reg_en` = 1, and to injected results (`res_injected` = 1) only when `g1_inj_en` = 1. Guards two and three react to both tags.
- R5: Bit i of `g2_mask` and of `g3_mask` selects channel i. A channel number of NUM_CH or above, a zero mask, or guard one with both enables clear never sets the flag.
- R6: A flag is sticky. An out-of-window result on a watched channel, strobed at one clock edge, makes the flag read 1 from that edge on. The flag stays 1 until it is cleared.
- R7: `flag_clr` is write-1-to-clear, one bit per guard: bit 0 is guard one, bit 1 is guard two, bit 2 is guard three. Clearing one flag leaves the other flags unchanged. If a set event and a clear arrive in the same cycle, the set wins.
- R8: `irq` is registered and equals the OR of `flags & irq_en`. It updates on the same edge as the flags. `irq_en` bit i enables flag i.
- R9: With a filter value F on `g1_filt`, guard one sets its flag on the (F+1)-th consecutive out-of-window result on a watched channel. An in-window watched result resets the run. A result that guard one does not watch leaves the run unchanged. The run restarts from zero each time it fires. F = 0 sets the flag on the first out-of-window result.
- R10: After reset, `flags` = 0, `irq` = 0 and the filter run is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe for a new result |
| res_chan | input | CH_W | Channel number of the result |
| res_value | input | DATA_W | Result value |
| res_injected | input | 1 | 1 = injected result, 0 = regular result |
| g1_lo | input | DATA_W | Guard one lower limit |
| g1_hi | input | DATA_W | Guard one upper limit |
| g1_all | input | 1 | Guard one: 1 = all channels, 0 = single channel |
| g1_chan | input | CH_W | Guard one single-channel select |
| g1_reg_en | input | 1 | Guard one enable for regular results |
| g1_inj_en | input | 1 | Guard one enable for injected results |
| g1_filt | input | FILT_W | Guard one consecutive-result filter value |
| g2_lo | input | DATA_W | Guard two lower limit |
| g2_hi | input | DATA_W | Guard two upper limit |
| g2_mask | input | NUM_CH | Guard two channel mask |
| g3_lo | input | DATA_W | Guard three lower limit |
| g3_hi | input | DATA_W | Guard three upper limit |
| g3_mask | input | NUM_CH | Guard three channel mask |
| flag_clr | input | 3 | Write-1-to-clear strobe per flag |
| irq_en | input | 3 | Interrupt enable per flag |
| flags | output | 3 | Sticky guard flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps result values across both limits. An off-by-one comparator would flag a value equal to a limit, or would miss the value just beyond it. It walks every channel through single, all and mask selection. A wrong decode would flag a foreign channel or stay silent on a watched one. It also pairs each tag with each enable, so a swapped tag enable shows up at once. For filter values 0 to 3 it checks that the flag appears on exactly the (F+1)-th consecutive outside result. It also checks that an in-window result restarts the run and that a result from another channel does not. A counter off by one, or one that never resets, fires a result too early or too late. Same-cycle set and clear, partial clears and every interrupt-enable pattern are checked as well. A clear that wins over a set, or an interrupt that lags the flags, would read wrong in the very next cycle.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int WG_NUM = 3;
  localparam int WG_ONE = 0;
  localparam int WG_TWO = 1;
  localparam int WG_THREE = 2;
endpackage

// File: rtl/wg_window.sv
module wg_window #(
  parameter int DATA_W = 25
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              outside
);
  // strictly beyond either limit; equality counts as inside
  assign outside = (value > hi) || (value < lo);
endmodule

// File: rtl/wg_pick_one.sv
module wg_pick_one #(
  parameter int CH_W = 5
) (
  input  logic [CH_W-1:0] chan,
  input  logic            injected,
  input  logic            all_mode,
  input  logic [CH_W-1:0] sel,
  input  logic            reg_en,
  input  logic            inj_en,
  output logic            hit
);
  logic tag_ok;
  assign tag_ok = injected ? inj_en : reg_en;
  assign hit    = tag_ok && (all_mode || (chan == sel));
endmodule

// File: rtl/wg_pick_mask.sv
module wg_pick_mask #(
  parameter int NUM_CH = 20,
  parameter int CH_W   = 5
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CH-1:0] mask,
  output logic              hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (mask[k] && (int'(chan) == k)) hit = 1'b1;
    end
  end
endmodule

// File: rtl/wg_flag_unit.sv
module wg_flag_unit #(
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic              ev_out,
  input  logic [FILT_W-1:0] filt,
  input  logic              clr,
  output logic              flag,
  output logic              flag_next
);
  logic [FILT_W-1:0] cnt;
  logic [FILT_W-1:0] cnt_d;
  logic              fire;

  always_comb begin
    fire  = 1'b0;
    cnt_d = cnt;
    if (ev) begin
      if (ev_out) begin
        if (cnt >= filt) begin
          fire  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  assign flag_next = (flag && !clr) || fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else begin
      flag <= flag_next;
      cnt  <= cnt_d;
    end
  end

  // R6
  set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(ev && ev_out));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(ev && ev_out)) |=> !flag);
  // R9
  run_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && !ev_out) |=> (cnt == '0));
endmodule

// File: rtl/result_window_guard.sv
module result_window_guard #(
  parameter int NUM_CH = 20,
  parameter int DATA_W = 25,
  parameter int FILT_W = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_injected,
  input  logic [DATA_W-1:0] g1_lo,
  input  logic [DATA_W-1:0] g1_hi,
  input  logic              g1_all,
  input  logic [CH_W-1:0]   g1_chan,
  input  logic              g1_reg_en,
  input  logic              g1_inj_en,
  input  logic [FILT_W-1:0] g1_filt,
  input  logic [DATA_W-1:0] g2_lo,
  input  logic [DATA_W-1:0] g2_hi,
  input  logic [NUM_CH-1:0] g2_mask,
  input  logic [DATA_W-1:0] g3_lo,
  input  logic [DATA_W-1:0] g3_hi,
  input  logic [NUM_CH-1:0] g3_mask,
  input  logic [2:0]        flag_clr,
  input  logic [2:0]        irq_en,
  output logic [2:0]        flags,
  output logic              irq
);
  import wg_pkg::*;

  logic [DATA_W-1:0] lo_arr [WG_NUM];
  logic [DATA_W-1:0] hi_arr [WG_NUM];
  logic [FILT_W-1:0] filt_arr [WG_NUM];
  logic [WG_NUM-1:0] flag_nx;

  assign lo_arr[WG_ONE]     = g1_lo;
  assign hi_arr[WG_ONE]     = g1_hi;
  assign lo_arr[WG_TWO]     = g2_lo;
  assign hi_arr[WG_TWO]     = g2_hi;
  assign lo_arr[WG_THREE]   = g3_lo;
  assign hi_arr[WG_THREE]   = g3_hi;
  assign filt_arr[WG_ONE]   = g1_filt;
  assign filt_arr[WG_TWO]   = '0;
  assign filt_arr[WG_THREE] = '0;

  for (genvar i = 0; i < WG_NUM; i++) begin : g_wd
    logic hit;
    logic outside;

    if (i == WG_ONE) begin : g_single
      wg_pick_one #(.CH_W(CH_W)) u_pick (
        .chan(res_chan), .injected(res_injected), .all_mode(g1_all),
        .sel(g1_chan), .reg_en(g1_reg_en), .inj_en(g1_inj_en), .hit(hit));
    end else begin : g_masked
      wg_pick_mask #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .chan(res_chan), .mask((i == WG_TWO) ? g2_mask : g3_mask), .hit(hit));
    end

    wg_window #(.DATA_W(DATA_W)) u_win (
      .value(res_value), .lo(lo_arr[i]), .hi(hi_arr[i]), .outside(outside));

    wg_flag_unit #(.FILT_W(FILT_W)) u_flag (
      .clk(clk), .rst(rst), .ev(res_valid && hit), .ev_out(outside),
      .filt(filt_arr[i]), .clr(flag_clr[i]), .flag(flags[i]),
      .flag_next(flag_nx[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_nx & irq_en);
  end

  // R8
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & $past(irq_en)));
  // R5
  idle_mask2_chk: assert property (@(posedge clk) disable iff (rst)
    (g2_mask == '0 && !flags[WG_TWO]) |=> !flags[WG_TWO]);
  // R5
  idle_mask3_chk: assert property (@(posedge clk) disable iff (rst)
    (g3_mask == '0 && !flags[WG_THREE]) |=> !flags[WG_THREE]);
  // R5
  idle_en1_chk: assert property (@(posedge clk) disable iff (rst)
    (!g1_reg_en && !g1_inj_en && !flags[WG_ONE]) |=> !flags[WG_ONE]);
endmodule

// File: tb/sim_result_window_guard.sv
module sim_result_window_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        res_valid = 0, res_injected = 0;
  logic [4:0]  res_chan = 0;
  logic [24:0] res_value = 0;
  logic [24:0] g1_lo = 0, g1_hi = 0, g2_lo = 0, g2_hi = 0, g3_lo = 0, g3_hi = 0;
  logic        g1_all = 0, g1_reg_en = 0, g1_inj_en = 0;
  logic [4:0]  g1_chan = 0;
  logic [2:0]  g1_filt = 0;
  logic [19:0] g2_mask = 0, g3_mask = 0;
  logic [2:0]  flag_clr = 0, irq_en = 0;
  logic [2:0]  flags;
  logic        irq;

  result_window_guard u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [2:0] ef = 0;
  int ecnt = 0;
  bit done = 0;

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, {1'b0, flags}, {1'b0, ef});
    chk(req, {3'b0, irq}, {3'b0, |(ef & irq_en)});
  endtask

  // drive one result; the model follows the requirements
  task automatic send(int ch, int v, bit inj, logic [2:0] clr);
    bit h1, h2, h3, o1, o2, o3;
    logic [2:0] set;
    @(negedge clk);
    res_valid = 1; res_chan = 5'(ch); res_value = 25'(v);
    res_injected = inj; flag_clr = clr;
    h1 = (inj ? g1_inj_en : g1_reg_en) && (g1_all || ch == int'(g1_chan));
    h2 = (ch < 20) && g2_mask[ch % 20];
    h3 = (ch < 20) && g3_mask[ch % 20];
    o1 = (v > int'(g1_hi)) || (v < int'(g1_lo));
    o2 = (v > int'(g2_hi)) || (v < int'(g2_lo));
    o3 = (v > int'(g3_hi)) || (v < int'(g3_lo));
    set = 0;
    if (h1) begin
      if (o1) begin
        if (ecnt >= int'(g1_filt)) begin set[0] = 1; ecnt = 0; end
        else ecnt++;
      end else ecnt = 0;
    end
    set[1] = h2 && o2;
    set[2] = h3 && o3;
    ef = (ef & ~clr) | set;
    @(negedge clk);
    res_valid = 0; flag_clr = 0;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk);
    flag_clr = m;
    ef = ef & ~m;
    @(negedge clk);
    flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk_all("R10");

    // R1 window sweep on guard two, guards one and three idle (R5)
    g2_lo = 10; g2_hi = 20; g2_mask = 20'h00008; irq_en = 3'b111;
    for (int v = 0; v < 32; v++) begin
      send(3, v, 0, 0);
      chk_all("R1");
      clear(3'b111);
    end

    // R5 mask decode on guard three, with out-of-range channels
    g2_mask = 0; g3_lo = 100; g3_hi = 200; g3_mask = 20'h0A5A5;
    for (int ch = 0; ch < 24; ch++) begin
      send(ch, 300, ch[0], 0);
      chk_all("R5");
      clear(3'b111);
    end
    g3_mask = 0;

    // R2 single channel, R3 all channels on guard one
    g1_lo = 50; g1_hi = 60; g1_reg_en = 1; g1_chan = 7;
    for (int ch = 0; ch < 20; ch++) begin
      send(ch, 61, 0, 0);
      chk_all("R2");
      clear(3'b111);
    end
    g1_all = 1;
    for (int ch = 0; ch < 20; ch++) begin
      send(ch, 49, 0, 0);
      chk_all("R3");
      clear(3'b111);
    end

    // R4 tag enables on guard one; guard two sees both tags
    g2_mask = 20'hFFFFF;
    for (int e = 0; e < 4; e++) begin
      g1_reg_en = e[0]; g1_inj_en = e[1];
      for (int t = 0; t < 2; t++) begin
        send(5, 1000, t[0], 0);
        chk_all("R4");
        clear(3'b111);
      end
    end
    g2_mask = 0; g1_reg_en = 1; g1_inj_en = 0;

    // R9 filter runs for F = 0..3, in-window restart, foreign results
    g1_all = 0; g1_chan = 2;
    for (int f = 0; f < 4; f++) begin
      g1_filt = 3'(f);
      send(2, 55, 0, 0);
      for (int k = 0; k < f; k++) begin
        send(2, 70, 0, 0);
        send(9, 55, 0, 0);
        chk_all("R9");
      end
      send(2, 55, 0, 0);
      chk_all("R9");
      for (int k = 0; k <= f; k++) begin
        send(2, 70, 0, 0);
        chk_all("R9");
      end
      clear(3'b111);
    end
    g1_filt = 0;

    // R7 set wins over clear, partial clears keep others
    g2_mask = 20'h00004; g3_mask = 20'h00004;
    send(2, 70, 0, 0);
    chk_all("R6");
    send(2, 70, 0, 3'b001);
    chk_all("R7");
    send(2, 55, 0, 3'b010);
    chk_all("R7");
    clear(3'b100);
    chk_all("R7");
    @(negedge clk);
    chk_all("R6");

    // R8 every interrupt enable pattern over mixed flag patterns
    for (int p = 0; p < 8; p++) begin
      clear(3'b111);
      g1_reg_en = p[0]; g2_mask = p[1] ? 20'h4 : 0; g3_mask = p[2] ? 20'h4 : 0;
      send(2, 500, 0, 0);
      for (int e = 0; e < 8; e++) begin
        @(negedge clk);
        irq_en = 3'(e);
        @(negedge clk);
        chk_all("R8");
      end
    end

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got=hang exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule